// File: doc/BRIEF.md
# Streaming Grayscale Template Matcher

The block takes one frame per job over an AXI4-Stream slave port. A frame is a single unbroken run of packed RGB pixels. The pixels of a small template image come first, in row-major order, and the pixels of a larger search image follow. Each pixel is reduced to 8-bit luma as it arrives and written into one of two internal buffers.

When the last pixel has arrived, the block walks a template-sized window over every position where the window fits entirely inside the search image. For each position it adds up the absolute luma differences between the window and the template. It compares that total against a limit and sends a single flag for the position out on an AXI4-Stream master port. The result is one bit per position, so a host can locate candidate hits without handling a full score map.

Image and template sizes are elaboration parameters. The match limit is an input port whose value is captured with the first pixel of each frame.

Top module: `sad_match_stream`

## Requirements
- R1: Each input word carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0. The block compares luma values Y = (77*red + 150*green + 29*blue) >> 8.
- R2: Each frame has TPL_W*TPL_H template pixels followed by SRC_W*SRC_H search pixels, both in row-major order. The block finds the end of the frame by counting pixels, because the input has no end marker.
- R3: For each window position, the output flag is 1 exactly when the sum of absolute luma differences between the window and the template is less than or equal to the captured limit.
- R4: The limit is taken from `match_limit` on the transfer of the first pixel of a frame. Later changes to `match_limit` within that frame have no effect on its flags.
- R5: The block emits exactly (SRC_W-TPL_W+1)*(SRC_H-TPL_H+1) flags per frame, in raster order: left to right along a row, then rows top to bottom. `m_tlast` is 1 on the final flag only.
- R6: `s_tready` is 0 from the transfer of the last pixel of a frame until the last flag has been transferred. It is 1 again in the cycle right after that transfer. While `m_tvalid` is 1, `s_tready` is 0.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, the flag and `m_tlast` hold their values and `m_tvalid` stays 1.
- R8: The sum does not overflow, even in the worst case of 255 times the number of template pixels. With a white template over a black search image, a limit equal to that worst case gives all flags 1, and a limit one below it gives all flags 0.
- R9: After reset, `s_tready` is 1 and `m_tvalid` is 0.
- R10: Frames sent one after another are independent. Every buffer entry is rewritten by each new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 24 | Packed RGB pixel |
| s_tvalid | input | 1 | Input pixel valid |
| s_tready | output | 1 | Block accepts a pixel |
| match_limit | input | SAD_W (12 by default) | Largest sum counted as a match, captured on the first pixel |
| m_tdata | output | 1 | Match flag for the current window position |
| m_tvalid | output | 1 | Flag valid |
| m_tready | input | 1 | Downstream accepts the flag |
| m_tlast | output | 1 | Marks the flag of the last window position |

## Verification
The matcher is exercised with several kinds of frame:
- **All-zero frame.** Every position must match at limit zero.
- **Embedded template.** The template is placed exactly once inside a patterned search image. Only that one position may match at limit zero, which separates correct window addressing and template/search ordering from shifted or transposed variants.
- **Limit-boundary frames.** The limit is set to the exact sum of a chosen position and to one less, which tells `<=` apart from `<`.
- **Worst-case frame.** A white template over a black image tests the accumulator width at the top of its range.
- **Pure-primary frame.** Pure red, green and blue pixels matched against gray equivalents separate the channel weights and bit positions.

Random output stalls and input gaps run alongside these frames. They show that flags hold under backpressure and that input is refused while the scan is running.

// File: rtl/sadm_pkg.sv
package sadm_pkg;

   typedef enum logic [1:0] {
      ST_LOAD = 2'd0,
      ST_SCAN = 2'd1,
      ST_EMIT = 2'd2
   } sadm_state_e;

   localparam int CH_W  = 8;
   localparam int PIX_W = 3 * CH_W;

   localparam int WT_R = 77;
   localparam int WT_G = 150;
   localparam int WT_B = 29;

   function automatic logic [CH_W-1:0] luma_of(input logic [PIX_W-1:0] rgb);
      logic [2*CH_W-1:0] wsum;
      wsum = (2*CH_W)'(rgb[3*CH_W-1:2*CH_W]) * (2*CH_W)'(WT_R)
           + (2*CH_W)'(rgb[2*CH_W-1:CH_W])   * (2*CH_W)'(WT_G)
           + (2*CH_W)'(rgb[CH_W-1:0])        * (2*CH_W)'(WT_B);
      return wsum[2*CH_W-1:CH_W];
   endfunction

endpackage

// File: rtl/sadm_luma.sv
module sadm_luma
   import sadm_pkg::*;
(
   input  logic [PIX_W-1:0] rgb,
   output logic [CH_W-1:0]  y
);
   always_comb y = luma_of(rgb);
endmodule

// File: rtl/sadm_bufs.sv
module sadm_bufs
   import sadm_pkg::*;
#(
   parameter int TPL_PIX = 16,
   parameter int SRC_PIX = 256,
   localparam int TA_W = (TPL_PIX > 1) ? $clog2(TPL_PIX) : 1,
   localparam int SA_W = (SRC_PIX > 1) ? $clog2(SRC_PIX) : 1
)(
   input  logic            clk,
   input  logic            tpl_we,
   input  logic            src_we,
   input  logic [TA_W-1:0] tpl_wa,
   input  logic [SA_W-1:0] src_wa,
   input  logic [CH_W-1:0] wd,
   input  logic [TA_W-1:0] tpl_ra,
   input  logic [SA_W-1:0] src_ra,
   output logic [CH_W-1:0] tpl_rd,
   output logic [CH_W-1:0] src_rd
);
   logic [CH_W-1:0] tpl_mem [TPL_PIX];
   logic [CH_W-1:0] src_mem [SRC_PIX];

   always_ff @(posedge clk) begin
      if (tpl_we) tpl_mem[tpl_wa] <= wd;
      if (src_we) src_mem[src_wa] <= wd;
   end

   always_comb begin
      tpl_rd = tpl_mem[tpl_ra];
      src_rd = src_mem[src_ra];
   end
endmodule

// File: rtl/sadm_ingest.sv
module sadm_ingest
   import sadm_pkg::*;
#(
   parameter int TPL_PIX = 16,
   parameter int SRC_PIX = 256,
   parameter int SAD_W   = 12,
   localparam int TOT    = TPL_PIX + SRC_PIX,
   localparam int CNT_W  = $clog2(TOT + 1),
   localparam int TA_W   = (TPL_PIX > 1) ? $clog2(TPL_PIX) : 1,
   localparam int SA_W   = (SRC_PIX > 1) ? $clog2(SRC_PIX) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_tvalid,
   output logic             s_tready,
   input  logic [SAD_W-1:0] limit_in,
   input  logic             scan_fin,
   output logic             tpl_we,
   output logic             src_we,
   output logic [TA_W-1:0]  tpl_wa,
   output logic [SA_W-1:0]  src_wa,
   output logic [SAD_W-1:0] limit_q,
   output logic             scan_go
);
   logic [CNT_W-1:0] cnt;
   logic             busy;
   logic             take;
   logic             in_tpl;

   always_comb begin
      s_tready = !busy;
      take     = s_tvalid && !busy;
      in_tpl   = 32'(cnt) < TPL_PIX;
      tpl_we   = take && in_tpl;
      src_we   = take && !in_tpl;
      tpl_wa   = TA_W'(cnt);
      src_wa   = SA_W'(32'(cnt) - TPL_PIX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         busy    <= 1'b0;
         limit_q <= '0;
         scan_go <= 1'b0;
      end else begin
         scan_go <= 1'b0;
         if (take) begin
            if (cnt == '0) limit_q <= limit_in;
            if (cnt == CNT_W'(TOT - 1)) begin
               cnt     <= '0;
               busy    <= 1'b1;
               scan_go <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (scan_fin) busy <= 1'b0;
      end
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) < TOT);

   // R2
   hold_count_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cnt));
endmodule

// File: rtl/sadm_scan.sv
module sadm_scan
   import sadm_pkg::*;
#(
   parameter int SRC_W = 16,
   parameter int SRC_H = 16,
   parameter int TPL_W = 4,
   parameter int TPL_H = 4,
   parameter int SAD_W = 12,
   localparam int TPL_PIX = TPL_W * TPL_H,
   localparam int SRC_PIX = SRC_W * SRC_H,
   localparam int POS_W   = SRC_W - TPL_W + 1,
   localparam int POS_H   = SRC_H - TPL_H + 1,
   localparam int DIM_MAX = (SRC_W > SRC_H) ? SRC_W : SRC_H,
   localparam int CW      = $clog2(DIM_MAX + 1),
   localparam int TA_W    = (TPL_PIX > 1) ? $clog2(TPL_PIX) : 1,
   localparam int SA_W    = (SRC_PIX > 1) ? $clog2(SRC_PIX) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_go,
   input  logic [SAD_W-1:0] limit_q,
   input  logic [CH_W-1:0]  tpl_rd,
   input  logic [CH_W-1:0]  src_rd,
   output logic [TA_W-1:0]  tpl_ra,
   output logic [SA_W-1:0]  src_ra,
   output logic             m_tvalid,
   output logic             m_tdata,
   output logic             m_tlast,
   input  logic             m_tready,
   output logic             scan_fin
);
   sadm_state_e      st;
   logic [CW-1:0]    px, py, tx, ty;
   logic [SAD_W-1:0] acc, acc_sum;
   logic [CH_W-1:0]  adiff;
   logic             last_k, last_pos;

   always_comb begin
      tpl_ra   = TA_W'(32'(ty) * TPL_W + 32'(tx));
      src_ra   = SA_W'((32'(py) + 32'(ty)) * SRC_W + 32'(px) + 32'(tx));
      adiff    = (src_rd > tpl_rd) ? (src_rd - tpl_rd) : (tpl_rd - src_rd);
      acc_sum  = acc + SAD_W'(adiff);
      last_k   = (tx == CW'(TPL_W - 1)) && (ty == CW'(TPL_H - 1));
      last_pos = (px == CW'(POS_W - 1)) && (py == CW'(POS_H - 1));
      scan_fin = (st == ST_EMIT) && m_tready && last_pos;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_LOAD;
         px       <= '0;
         py       <= '0;
         tx       <= '0;
         ty       <= '0;
         acc      <= '0;
         m_tvalid <= 1'b0;
         m_tdata  <= 1'b0;
         m_tlast  <= 1'b0;
      end else begin
         unique case (st)
            ST_LOAD: begin
               if (scan_go) begin
                  st  <= ST_SCAN;
                  px  <= '0;
                  py  <= '0;
                  tx  <= '0;
                  ty  <= '0;
                  acc <= '0;
               end
            end
            ST_SCAN: begin
               if (last_k) begin
                  m_tvalid <= 1'b1;
                  m_tdata  <= (acc_sum <= limit_q);
                  m_tlast  <= last_pos;
                  acc      <= '0;
                  tx       <= '0;
                  ty       <= '0;
                  st       <= ST_EMIT;
               end else begin
                  acc <= acc_sum;
                  if (tx == CW'(TPL_W - 1)) begin
                     tx <= '0;
                     ty <= ty + 1'b1;
                  end else begin
                     tx <= tx + 1'b1;
                  end
               end
            end
            ST_EMIT: begin
               if (m_tready) begin
                  m_tvalid <= 1'b0;
                  m_tlast  <= 1'b0;
                  if (last_pos) begin
                     px <= '0;
                     py <= '0;
                     st <= ST_LOAD;
                  end else begin
                     st <= ST_SCAN;
                     if (px == CW'(POS_W - 1)) begin
                        px <= '0;
                        py <= py + 1'b1;
                     end else begin
                        px <= px + 1'b1;
                     end
                  end
               end
            end
            default: st <= ST_LOAD;
         endcase
      end
   end

   // R8
   acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SCAN) |-> (acc_sum >= acc));

   // R7
   hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

   // R5
   last_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tlast |-> m_tvalid);
endmodule

// File: rtl/sad_match_stream.sv
module sad_match_stream
   import sadm_pkg::*;
#(
   parameter int SRC_W = 16,
   parameter int SRC_H = 16,
   parameter int TPL_W = 4,
   parameter int TPL_H = 4,
   localparam int TPL_PIX = TPL_W * TPL_H,
   localparam int SRC_PIX = SRC_W * SRC_H,
   localparam int SAD_W   = $clog2(255 * TPL_PIX + 1),
   localparam int TA_W    = (TPL_PIX > 1) ? $clog2(TPL_PIX) : 1,
   localparam int SA_W    = (SRC_PIX > 1) ? $clog2(SRC_PIX) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [23:0]      s_tdata,
   input  logic             s_tvalid,
   output logic             s_tready,
   input  logic [SAD_W-1:0] match_limit,
   output logic             m_tdata,
   output logic             m_tvalid,
   input  logic             m_tready,
   output logic             m_tlast
);
   initial begin
      size_w_chk: assert (TPL_W >= 1 && TPL_W <= SRC_W)
         else $error("template width must be 1..SRC_W");
      size_h_chk: assert (TPL_H >= 1 && TPL_H <= SRC_H)
         else $error("template height must be 1..SRC_H");
      pix_w_chk: assert (PIX_W == 24)
         else $error("pixel word must be 24 bits");
   end

   logic [CH_W-1:0]  y;
   logic             tpl_we, src_we, scan_go, scan_fin;
   logic [TA_W-1:0]  tpl_wa, tpl_ra;
   logic [SA_W-1:0]  src_wa, src_ra;
   logic [CH_W-1:0]  tpl_rd, src_rd;
   logic [SAD_W-1:0] limit_q;

   sadm_luma u_luma (.rgb(s_tdata), .y(y));

   sadm_ingest #(.TPL_PIX(TPL_PIX), .SRC_PIX(SRC_PIX), .SAD_W(SAD_W)) u_ingest (
      .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
      .limit_in(match_limit), .scan_fin(scan_fin), .tpl_we(tpl_we), .src_we(src_we),
      .tpl_wa(tpl_wa), .src_wa(src_wa), .limit_q(limit_q), .scan_go(scan_go)
   );

   sadm_bufs #(.TPL_PIX(TPL_PIX), .SRC_PIX(SRC_PIX)) u_bufs (
      .clk(clk), .tpl_we(tpl_we), .src_we(src_we), .tpl_wa(tpl_wa), .src_wa(src_wa),
      .wd(y), .tpl_ra(tpl_ra), .src_ra(src_ra), .tpl_rd(tpl_rd), .src_rd(src_rd)
   );

   sadm_scan #(.SRC_W(SRC_W), .SRC_H(SRC_H), .TPL_W(TPL_W), .TPL_H(TPL_H),
               .SAD_W(SAD_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .scan_go(scan_go), .limit_q(limit_q),
      .tpl_rd(tpl_rd), .src_rd(src_rd), .tpl_ra(tpl_ra), .src_ra(src_ra),
      .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast),
      .m_tready(m_tready), .scan_fin(scan_fin)
   );

   // R6
   no_input_while_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> !s_tready);

   // R6
   reopen_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && m_tready && m_tlast) |=> s_tready);
endmodule

// File: tb/sim_sad_match_stream.sv
module sim_sad_match_stream;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 6, SH = 5, TW = 3, TH = 2;
   localparam int TP = TW * TH, SP = SW * SH, TOT = TP + SP;
   localparam int PW = SW - TW + 1, PH = SH - TH + 1, NPOS = PW * PH;
   localparam int SADW = $clog2(255 * TP + 1);
   localparam int LMAX = (1 << SADW) - 1;

   logic clk = 0, rst_n = 0;
   logic [23:0] s_tdata = '0;
   logic s_tvalid = 0, s_tready;
   logic [SADW-1:0] match_limit = '0;
   logic m_tdata, m_tvalid, m_tlast;
   logic m_tready = 0;

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;

   logic [23:0] pix [TOT];
   int sad_ref [NPOS];
   bit got [NPOS];
   bit got_last [NPOS];
   int got_n, hold_bad, rdy_bad;

   always #(CLK_PERIOD/2) clk = ~clk;

   sad_match_stream #(.SRC_W(SW), .SRC_H(SH), .TPL_W(TW), .TPL_H(TH)) u0 (
      .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
      .s_tready(s_tready), .match_limit(match_limit), .m_tdata(m_tdata),
      .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   function automatic int luma(input logic [23:0] p);
      return (77 * int'(p[23:16]) + 150 * int'(p[15:8]) + 29 * int'(p[7:0])) / 256;
   endfunction

   function automatic logic [23:0] gray_px(input int v);
      return {8'(v), 8'(v), 8'(v)};
   endfunction

   task automatic compute_ref();
      for (int py = 0; py < PH; py++)
         for (int px = 0; px < PW; px++) begin
            int s = 0;
            for (int ty = 0; ty < TH; ty++)
               for (int tx = 0; tx < TW; tx++) begin
                  int a = luma(pix[ty*TW + tx]);
                  int b = luma(pix[TP + (py+ty)*SW + px + tx]);
                  s += (a > b) ? a - b : b - a;
               end
            sad_ref[py*PW + px] = s;
         end
   endtask

   task automatic drive_in(input int lim, input bit gaps);
      bit go;
      match_limit = SADW'(lim);
      for (int i = 0; i < TOT; i++) begin
         @(negedge clk);
         if (gaps && (i % 3 == 1)) begin
            s_tvalid = 0;
            @(negedge clk);
         end
         s_tvalid = 1;
         s_tdata  = pix[i];
         if (i == 1) match_limit = SADW'(LMAX - lim);
         forever begin
            go = s_tready;
            @(posedge clk);
            if (go) break;
            @(negedge clk);
         end
      end
      @(negedge clk);
      s_tvalid = 0;
   endtask

   task automatic collect(input bit stall);
      bit pstall = 0;
      bit pdata = 0, plast = 0;
      got_n = 0; hold_bad = 0; rdy_bad = 0;
      while (got_n < NPOS) begin
         @(negedge clk);
         if (pstall && !(m_tvalid && m_tdata == pdata && m_tlast == plast)) hold_bad++;
         if (m_tvalid && s_tready) rdy_bad++;
         m_tready = stall ? ($urandom % 3 != 0) : 1'b1;
         pstall = m_tvalid && !m_tready;
         pdata = m_tdata; plast = m_tlast;
         if (m_tvalid && m_tready) begin
            got[got_n] = m_tdata;
            got_last[got_n] = m_tlast;
            got_n++;
         end
      end
      @(negedge clk);
      m_tready = 0;
      chk(s_tready === 1'b1, "R6", "s_tready after last flag", int'(s_tready), 1);
   endtask

   task automatic run_frame(input int lim, input bit gaps, input bit stall,
                            input string req);
      int bad = 0, first = -1, ones = 0, lastbad = 0;
      compute_ref();
      fork
         drive_in(lim, gaps);
         collect(stall);
      join
      for (int k = 0; k < NPOS; k++) begin
         bit e = (sad_ref[k] <= lim);
         if (got[k] !== e) begin bad++; if (first < 0) first = k; end
         if (got[k]) ones++;
         if (got_last[k] !== (k == NPOS - 1)) lastbad++;
      end
      chk(bad == 0, req, $sformatf("flag mismatches (first pos %0d)", first), bad, 0);
      chk(lastbad == 0, "R5", "tlast misplaced count", lastbad, 0);
      chk(hold_bad == 0, "R7", "flag changed under stall", hold_bad, 0);
      chk(rdy_bad == 0, "R6", "s_tready high while flag valid", rdy_bad, 0);
      checks++;
      if (bad == 0) ; else $display("  frame ones=%0d", ones);
   endtask

   task automatic fill_const(input logic [23:0] t, input logic [23:0] s);
      for (int i = 0; i < TP; i++) pix[i] = t;
      for (int i = TP; i < TOT; i++) pix[i] = s;
   endtask

   task automatic fill_embed(input int ox, input int oy);
      for (int i = 0; i < TP; i++) pix[i] = gray_px(40 + 25 * i);
      for (int y = 0; y < SH; y++)
         for (int x = 0; x < SW; x++)
            pix[TP + y*SW + x] = gray_px(200 - 7 * (y*SW + x));
      for (int ty = 0; ty < TH; ty++)
         for (int tx = 0; tx < TW; tx++)
            pix[TP + (oy+ty)*SW + ox + tx] = pix[ty*TW + tx];
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9: reset state
      chk(s_tready === 1'b1, "R9", "s_tready after reset", int'(s_tready), 1);
      chk(m_tvalid === 1'b0, "R9", "m_tvalid after reset", int'(m_tvalid), 0);

      // R3: flat frame, all positions equal at limit 0
      fill_const(24'h000000, 24'h000000);
      run_frame(0, 0, 0, "R3");

      // R2 R4: single embedded copy at (2,1); late limit change to max must not count
      fill_embed(2, 1);
      run_frame(0, 1, 1, "R2");
      chk(got[1*PW + 2] == 1'b1, "R4", "embedded position flag", int'(got[1*PW+2]), 1);
      chk(got[0] == 1'b0, "R4", "non-matching position flag", int'(got[0]), 0);

      // R3 boundary: limit equal to a position's sum, then one below
      fill_embed(1, 2);
      compute_ref();
      run_frame(sad_ref[5], 0, 1, "R3");
      chk(got[5] == 1'b1, "R3", "flag at limit == sum", int'(got[5]), 1);
      run_frame(sad_ref[5] - 1, 1, 0, "R3");
      chk(got[5] == 1'b0, "R3", "flag at limit == sum-1", int'(got[5]), 0);

      // R8: white template over black image, worst-case sum
      fill_const(24'hFFFFFF, 24'h000000);
      run_frame(255 * TP, 0, 1, "R8");
      chk(got[NPOS-1] == 1'b1, "R8", "worst-case sum at limit", int'(got[NPOS-1]), 1);
      run_frame(255 * TP - 1, 1, 1, "R8");
      chk(got[0] == 1'b0, "R8", "worst-case sum above limit", int'(got[0]), 0);

      // R1: pure primaries against gray equivalents at (3,0)
      for (int i = 0; i < TP; i++)
         pix[i] = (i % 3 == 0) ? 24'hFF0000 : (i % 3 == 1) ? 24'h00FF00 : 24'h0000FF;
      for (int i = TP; i < TOT; i++) pix[i] = 24'h102030;
      for (int ty = 0; ty < TH; ty++)
         for (int tx = 0; tx < TW; tx++)
            pix[TP + ty*SW + 3 + tx] = gray_px(luma(pix[ty*TW + tx]));
      run_frame(0, 0, 1, "R1");
      chk(got[3] == 1'b1, "R1", "primary template vs gray copy", int'(got[3]), 1);

      // R10: flat frame again after the worst-case frames
      fill_const(24'h0A0B0C, 24'h0A0B0C);
      run_frame(0, 1, 1, "R10");
      chk(got_n == NPOS, "R5", "flags per frame", got_n, NPOS);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule